// File: doc/BRIEF.md
# Field Rate Vertical Divider Controller

This block follows the vertical timing of an incoming video signal and produces a clean vertical sync pulse for 50 Hz and 60 Hz fields. It advances on a strobe that arrives twice per video line, so every count is one half-line. A separated sync input is sampled on those strobes, and a two-bit score records how reliably incoming sync lands near the expected position. The score selects the behaviour for the rest of each field. With a high score the block keeps time by itself and issues the pulse on schedule. With a middling score it follows incoming sync that falls inside a tolerance window. With a zero score it follows any incoming sync.

A field always opens in a counting phase of 488 half-lines, during which incoming sync is not followed. When the block follows incoming sync, the counter reads zero on the strobe after the one on which the sync edge was seen. When the block runs by itself it passes through a one-strobe wait state. On leaving that state it reloads the counter, so that the field length stays at 625 half-lines for 50 Hz and 525 for 60 Hz. The field standard is either detected from the position of the sync that is followed, or held by a forcing input.

Top module: `field_rate_divider`

## Requirements
- R1: After a synchronous reset `vsync_out` and `field_60` are low, and the half-line counter starts from zero.
- R2: A rising sync edge seen while fewer than 488 half-lines have passed in the current field produces no output pulse.
- R3: When the count reaches 488 the block chooses free-running mode for a score of 3, windowed mode for a score of 1 or 2, and search mode for a score of 0.
- R4: A sync edge at a count within 4 of the nominal position (624 for 50 Hz, 524 for 60 Hz) raises the score, which saturates at 3. Any other sync edge lowers it, saturating at 0. A free-running or windowed field that reaches its exit count without an in-window edge also lowers it.
- R5: In search mode every sync edge is followed. The output pulse starts on that strobe and the counter is cleared. In automatic mode the standard becomes 60 Hz if the count at the edge is 574 or less, and 50 Hz otherwise. If no edge arrives by count 800, the block goes to the wait state.
- R6: In windowed mode an in-window edge is followed in the same way as in search mode. If the exit count (626 for 50 Hz, 526 for 60 Hz) is reached first, the block goes to the wait state.
- R7: In free-running mode the block starts its own pulse at the nominal position whether or not input sync is present, and goes to the wait state at the exit count.
- R8: The wait state lasts one strobe and then returns to counting with the counter loaded to 3, so a free-running field is 625 or 525 half-lines long.
- R9: Every output pulse is exactly 6 half-lines long.
- R10: With `auto_en` low, `field_60` equals `force_60` one clock later and is not changed by detection. Sync edges are still followed in search mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hl_en | input | 1 | One-clock strobe at twice the line rate |
| vsync_in | input | 1 | Separated incoming vertical sync, active high |
| auto_en | input | 1 | 1: detect the field standard; 0: use `force_60` |
| force_60 | input | 1 | Forced standard: 1 = 60 Hz, 0 = 50 Hz |
| vsync_out | output | 1 | Vertical sync pulse, registered |
| field_60 | output | 1 | Current standard: 1 = 60 Hz, 0 = 50 Hz |

## Verification
The bench drives a sync edge early in a field, which shows whether the counting phase ignores sync. A first lock-on edge at an arbitrary position shows that search mode follows sync and picks the standard. Steady trains at 625 and 525 half-lines show that the score climbs into free-running mode with the output aligned to the input. Each standard also gets a single dropped edge, which must be replaced by a pulse the block generates itself at the exact field period. An edge three half-lines early right after the drop must be followed in windowed mode. A forced standard that disagrees with the incoming 525-half-line train must keep `field_60` fixed while the output still tracks the input.

// File: rtl/vdiv_pkg.sv
package vdiv_pkg;
  typedef enum logic [2:0] {
    ST_COUNT  = 3'd0,
    ST_NORM   = 3'd1,
    ST_NEAR   = 3'd2,
    ST_NONORM = 3'd3,
    ST_WAIT   = 3'd4
  } vdiv_state_e;
endpackage

// File: rtl/vdiv_hl_counter.sv
module vdiv_hl_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (tick) begin
      if (load)                cnt <= load_val;
      else if (cnt != CNT_TOP) cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    (tick && load) |=> cnt == $past(load_val)); // R8
endmodule

// File: rtl/vdiv_norm_score.sv
module vdiv_norm_score #(
  parameter int SCORE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd,
  input  logic               up,
  output logic [SCORE_W-1:0] score
);
  localparam logic [SCORE_W-1:0] S_MAX = {SCORE_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      score <= '0;
    end else if (upd) begin
      if (up) begin
        if (score != S_MAX) score <= score + 1'b1;
      end else begin
        if (score != '0) score <= score - 1'b1;
      end
    end
  end

  AST_SCORE_SAT_HI: assert property (@(posedge clk) disable iff (rst)
    (upd && up && score == S_MAX) |=> score == S_MAX); // R4
  AST_SCORE_SAT_LO: assert property (@(posedge clk) disable iff (rst)
    (upd && !up && score == '0) |=> score == '0); // R4
endmodule

// File: rtl/vdiv_pulse_gen.sv
module vdiv_pulse_gen #(
  parameter int VSP_LEN = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic start,
  output logic pulse
);
  localparam int LW = $clog2(VSP_LEN + 1);
  localparam logic [LW-1:0] LEFT_INIT = LW'(VSP_LEN - 1);

  logic [LW-1:0] left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pulse  <= 1'b0;
      left_q <= '0;
    end else if (tick) begin
      if (start) begin
        pulse  <= 1'b1;
        left_q <= LEFT_INIT;
      end else if (left_q != '0) begin
        left_q <= left_q - 1'b1;
      end else begin
        pulse <= 1'b0;
      end
    end
  end

  AST_PULSE_START: assert property (@(posedge clk) disable iff (rst)
    (tick && start) |=> pulse); // R9
  AST_PULSE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(pulse) |-> $past(tick && start)); // R9
endmodule

// File: rtl/field_rate_divider.sv
module field_rate_divider #(
  parameter int CNT_W          = 10,
  parameter int SCORE_W        = 2,
  parameter int BRANCH_AT      = 488,
  parameter int PERIOD_50      = 625,
  parameter int PERIOD_60      = 525,
  parameter int EXIT_50        = 626,
  parameter int EXIT_60        = 526,
  parameter int WIN            = 4,
  parameter int VSP_LEN        = 6,
  parameter int SEARCH_TIMEOUT = 800
) (
  input  logic clk,
  input  logic rst,
  input  logic hl_en,
  input  logic vsync_in,
  input  logic auto_en,
  input  logic force_60,
  output logic vsync_out,
  output logic field_60
);
  import vdiv_pkg::*;

  localparam int NOM_50 = PERIOD_50 - 1;
  localparam int NOM_60 = PERIOD_60 - 1;
  localparam logic [CNT_W-1:0] BR_C    = CNT_W'(BRANCH_AT);
  localparam logic [CNT_W-1:0] NOM50_C = CNT_W'(NOM_50);
  localparam logic [CNT_W-1:0] NOM60_C = CNT_W'(NOM_60);
  localparam logic [CNT_W-1:0] LO50_C  = CNT_W'(NOM_50 - WIN);
  localparam logic [CNT_W-1:0] HI50_C  = CNT_W'(NOM_50 + WIN);
  localparam logic [CNT_W-1:0] LO60_C  = CNT_W'(NOM_60 - WIN);
  localparam logic [CNT_W-1:0] HI60_C  = CNT_W'(NOM_60 + WIN);
  localparam logic [CNT_W-1:0] EX50_C  = CNT_W'(EXIT_50);
  localparam logic [CNT_W-1:0] EX60_C  = CNT_W'(EXIT_60);
  localparam logic [CNT_W-1:0] LD50_C  = CNT_W'(EXIT_50 - NOM_50 + 1);
  localparam logic [CNT_W-1:0] LD60_C  = CNT_W'(EXIT_60 - NOM_60 + 1);
  localparam logic [CNT_W-1:0] SPLIT_C = CNT_W'((NOM_50 + NOM_60) / 2);
  localparam logic [CNT_W-1:0] TMO_C   = CNT_W'(SEARCH_TIMEOUT);
  localparam logic [SCORE_W-1:0] S_MAX = {SCORE_W{1'b1}};

  vdiv_state_e        state_q, state_d;
  logic [CNT_W-1:0]   cnt;
  logic [SCORE_W-1:0] score;
  logic               vs_prev_q, seen_q, rate_q;
  logic               rise, in_win;
  logic               cnt_load, gen, sc_upd, sc_up;
  logic               seen_set, seen_clr, rate_set, rate_val;
  logic [CNT_W-1:0]   load_val, nom, lo, hi, exitc, wload;

  // Per-standard timing points
  always_comb begin
    nom   = rate_q ? NOM60_C : NOM50_C;
    lo    = rate_q ? LO60_C  : LO50_C;
    hi    = rate_q ? HI60_C  : HI50_C;
    exitc = rate_q ? EX60_C  : EX50_C;
    wload = rate_q ? LD60_C  : LD50_C;
  end

  assign rise   = hl_en && vsync_in && !vs_prev_q;
  assign in_win = (cnt >= lo) && (cnt <= hi);

  always_comb begin
    state_d  = state_q;
    cnt_load = 1'b0;
    load_val = '0;
    gen      = 1'b0;
    sc_upd   = 1'b0;
    sc_up    = 1'b0;
    seen_set = 1'b0;
    seen_clr = 1'b0;
    rate_set = 1'b0;
    rate_val = rate_q;
    if (hl_en) begin
      if (rise) begin
        sc_upd   = 1'b1;
        sc_up    = in_win;
        seen_set = in_win;
      end
      unique case (state_q)
        ST_COUNT: begin
          if (cnt == BR_C) begin
            if (score == S_MAX)    state_d = ST_NORM;
            else if (score == '0)  state_d = ST_NONORM;
            else                   state_d = ST_NEAR;
          end
        end
        ST_NORM: begin
          if (cnt == nom) gen = 1'b1;
          if (cnt == exitc) begin
            state_d = ST_WAIT;
            if (!seen_q && !rise) sc_upd = 1'b1;
          end
        end
        ST_NEAR: begin
          if (rise && in_win) begin
            gen      = 1'b1;
            cnt_load = 1'b1;
            seen_clr = 1'b1;
            state_d  = ST_COUNT;
          end else if (cnt == exitc) begin
            state_d = ST_WAIT;
            if (!seen_q && !rise) sc_upd = 1'b1;
          end
        end
        ST_NONORM: begin
          if (rise) begin
            gen      = 1'b1;
            cnt_load = 1'b1;
            seen_clr = 1'b1;
            state_d  = ST_COUNT;
            rate_set = 1'b1;
            rate_val = (cnt <= SPLIT_C);
          end else if (cnt == TMO_C) begin
            state_d = ST_WAIT;
          end
        end
        ST_WAIT: begin
          cnt_load = 1'b1;
          load_val = wload;
          seen_clr = 1'b1;
          state_d  = ST_COUNT;
        end
        default: state_d = ST_COUNT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_COUNT;
      vs_prev_q <= 1'b0;
      seen_q    <= 1'b0;
      rate_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (hl_en) vs_prev_q <= vsync_in;
      if (seen_clr)      seen_q <= 1'b0;
      else if (seen_set) seen_q <= 1'b1;
      if (!auto_en)      rate_q <= force_60;
      else if (rate_set) rate_q <= rate_val;
    end
  end

  assign field_60 = rate_q;

  vdiv_hl_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(hl_en), .load(cnt_load),
    .load_val(load_val), .cnt(cnt)
  );

  vdiv_norm_score #(.SCORE_W(SCORE_W)) u_score (
    .clk(clk), .rst(rst), .upd(sc_upd), .up(sc_up), .score(score)
  );

  vdiv_pulse_gen #(.VSP_LEN(VSP_LEN)) u_pulse (
    .clk(clk), .rst(rst), .tick(hl_en), .start(gen), .pulse(vsync_out)
  );

  AST_BRANCH_NORM: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COUNT && hl_en && cnt == BR_C && score == S_MAX) |=> state_q == ST_NORM); // R3
  AST_BRANCH_SEARCH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COUNT && hl_en && cnt == BR_C && score == '0) |=> state_q == ST_NONORM); // R3
  AST_COUNT_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_COUNT && hl_en && !vsync_out) |=> !vsync_out); // R2
  AST_FREE_EXIT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NORM && hl_en && cnt == exitc) |=> state_q == ST_WAIT); // R7
  AST_WAIT_ONE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && hl_en) |=> (state_q == ST_COUNT && cnt == $past(wload))); // R8
  AST_FOLLOW_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_NONORM && rise) |=> (cnt == '0 && vsync_out)); // R5
  AST_FORCED_RATE: assert property (@(posedge clk) disable iff (rst)
    !auto_en |=> field_60 == $past(force_60)); // R10
endmodule

// File: tb/sim_field_rate_divider.sv
module sim_field_rate_divider;
  logic clk = 1'b0;
  logic rst, hl_en, vsync_in, auto_en, force_60;
  logic vsync_out, field_60;

  always #4 clk = ~clk;

  field_rate_divider u0 (
    .clk(clk), .rst(rst), .hl_en(hl_en), .vsync_in(vsync_in),
    .auto_en(auto_en), .force_60(force_60),
    .vsync_out(vsync_out), .field_60(field_60)
  );

  int checks = 0;
  int errors = 0;
  int tk = 0;
  int sched = -1000;
  int last_rise = -1;
  int run_len = 0;
  int last_width = 0;
  logic prev_o = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One half-line strobe: four clocks, strobe high in the first
  task automatic do_tick();
    @(negedge clk);
    hl_en    = 1'b1;
    vsync_in = (tk >= sched) && (tk < sched + 5);
    @(negedge clk);
    hl_en = 1'b0;
    if (vsync_out && !prev_o) last_rise = tk;
    if (vsync_out) run_len++;
    else if (prev_o) begin
      last_width = run_len;
      run_len    = 0;
    end
    prev_o = vsync_out;
    tk++;
    repeat (2) @(negedge clk);
  endtask

  task automatic run_to(input int t);
    while (tk <= t) do_tick();
  endtask

  // Next incoming edge one period later; output must coincide with it
  task automatic field_follow(input int per, input string req);
    sched     = sched + per;
    last_rise = -1;
    run_to(sched + 8);
    chk(last_rise == sched, req, last_rise, sched);
    chk(last_width == 6, "R9 width", last_width, 6);
  endtask

  task automatic main_seq();
    int e;
    rst = 1'b1; hl_en = 1'b0; vsync_in = 1'b0; auto_en = 1'b1; force_60 = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(vsync_out == 1'b0, "R1 vsync_out", int'(vsync_out), 0);
    chk(field_60 == 1'b0, "R1 field_60", int'(field_60), 0);

    // R2: edge during the counting phase is not followed
    sched = 100; last_rise = -1;
    run_to(300);
    chk(last_rise == -1, "R2 early edge", last_rise, -1);

    // R5: search mode follows the first edge after count 488; 700 -> 50 Hz
    sched = 700; last_rise = -1;
    run_to(708);
    chk(last_rise == 700, "R5 search follow", last_rise, 700);
    chk(last_width == 6, "R9 width", last_width, 6);
    chk(field_60 == 1'b0, "R5 rate 50", int'(field_60), 0);

    // R3 R4: steady 50 Hz train lifts the score into free-running mode
    for (int i = 0; i < 6; i++) field_follow(625, "R3 R4 50Hz lock");

    // R7 R8: one missing edge is replaced by a self-timed pulse
    e = sched + 625;
    last_rise = -1;
    run_to(e + 8);
    chk(last_rise == e, "R7 R8 flywheel 50", last_rise, e);

    // R4 R6: score fell to 2; an edge 3 early is followed in windowed mode
    sched = e + 622; last_rise = -1;
    run_to(sched + 8);
    chk(last_rise == sched, "R4 R6 windowed follow", last_rise, sched);
    for (int i = 0; i < 3; i++) field_follow(625, "R6 relock 50Hz");

    // R5: 60 Hz train, automatic detection
    for (int i = 0; i < 20; i++) begin
      sched = sched + 525;
      run_to(sched + 8);
    end
    for (int i = 0; i < 3; i++) field_follow(525, "R5 60Hz lock");
    chk(field_60 == 1'b1, "R5 rate 60", int'(field_60), 1);

    e = sched + 525;
    last_rise = -1;
    run_to(e + 8);
    chk(last_rise == e, "R7 R8 flywheel 60", last_rise, e);
    sched = e;
    field_follow(525, "R6 resume 60Hz");

    // R10: forced standard
    auto_en = 1'b0; force_60 = 1'b0;
    do_tick();
    chk(field_60 == 1'b0, "R10 forced 50", int'(field_60), 0);
    for (int i = 0; i < 10; i++) begin
      sched = sched + 525;
      run_to(sched + 8);
    end
    chk(field_60 == 1'b0, "R10 held against 60Hz input", int'(field_60), 0);
    field_follow(525, "R10 follow while forced");
    force_60 = 1'b1;
    do_tick();
    chk(field_60 == 1'b1, "R10 forced 60", int'(field_60), 1);
  endtask

  initial begin
    fork
      main_seq();
      begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", tk, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule